// File: doc/BRIEF.md
# Buffered Four-Channel PWM Timer

This block is an up-counting timer that produces four pulse-width outputs. A prescaler divides the system clock to form the counter tick. The counter climbs from zero to a programmed top value and then restarts at zero. Each output is high while the count is below that channel's threshold, so one top value sets the period and four thresholds set the four duty cycles. A typical use is driving the two legs of two H-bridges.

Software programs the block through a single-cycle write port. The divider, the top value and the thresholds are written into holding registers. They reach the working registers only at an update event, so a new period or duty cycle never starts in the middle of a cycle. An update event happens when the counter wraps, or when software sets the one-shot update strobe. Each threshold can instead be written straight through by clearing its per-channel buffering bit. A global output gate and four per-channel gates decide which outputs may go high. A gated output is held low.

Top module: `pwm4_timer`

## Requirements
- R1: While running, the count goes 0, 1, … up to the active top value, then returns to 0 on the next tick, so one period is top+1 ticks.
- R2: The counter advances once every divider+1 clock cycles, where divider is the active value written at address 2.
- R3: Writes to the top value (address 3) and to the divider (address 2) change nothing until the next update event. The current period finishes with the old values.
- R4: Channel i's threshold is written at address 4+i. When its buffering bit (address 1, bit 4+i) is set, the new threshold takes effect only at an update event. When that bit is clear, the new threshold takes effect on the cycle after the write.
- R5: Writing address 0 with bit 2 set loads every holding register into its working register. It clears the counter and the prescaler, and it raises the update pulse on the next cycle. The strobe is not stored.
- R6: An enabled output is high exactly while count < threshold. A threshold of 0 gives a constant low. A threshold above the top value gives a constant high.
- R7: Output i can be high only when its enable (address 1, bit i) and the global output gate (address 0, bit 1) are both set. Otherwise it is low.
- R8: With the run bit (address 0, bit 0) clear, the count holds its value.
- R9: Each counter wrap produces an update pulse that lasts exactly one cycle, in the cycle after the wrap.
- R10: After synchronous reset, the count is 0, all outputs are low and the update pulse is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 4 | Register address |
| wr_data | input | CNT_W | Write data |
| pwm_o | output | NUM_CH | Pulse-width outputs |
| count_o | output | CNT_W | Current counter value |
| upd_o | output | 1 | One-cycle update pulse |

## Verification
The hardest case to reach is a write that lands in the middle of a running period. The write must be visibly ignored until the wrap and then applied. The stimulus polls the count at the port until it reaches a chosen value and writes at that exact cycle. It then follows the count or the output across the wrap. This shows that the old top value, divider or threshold still governs the rest of the period. The write-through path gets the same mid-period treatment: the threshold is chosen so that the buffered and the unbuffered behaviour give opposite output levels.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;

    localparam int ADDR_W = 4;

    // register addresses
    localparam logic [ADDR_W-1:0] RA_CTRL   = 4'd0;
    localparam logic [ADDR_W-1:0] RA_CHCFG  = 4'd1;
    localparam logic [ADDR_W-1:0] RA_PSC    = 4'd2;
    localparam logic [ADDR_W-1:0] RA_RELOAD = 4'd3;
    localparam logic [ADDR_W-1:0] RA_CMP0   = 4'd4;

    // control word bit positions
    localparam int CB_CEN = 0;
    localparam int CB_MOE = 1;
    localparam int CB_UG  = 2;

    typedef struct packed {
        logic moe;
        logic cen;
    } run_ctl_t;

    // level of an edge-aligned, active-high mode-1 output
    function automatic logic mode1_high(input int unsigned cnt, input int unsigned thr);
        return cnt < thr;
    endfunction

endpackage

// File: rtl/pwm4_prescaler.sv
module pwm4_prescaler
    import pwm4_pkg::*;
#(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             psc_wr,
    input  logic [PSC_W-1:0] psc_wdata,
    input  logic             upd_evt,
    input  logic             force_upd,
    output logic             tick
);

    logic [PSC_W-1:0] psc_sh, psc_act, pcnt;

    assign tick = run && !force_upd && (pcnt == psc_act);

    always_ff @(posedge clk) begin
        if (rst) begin
            psc_sh  <= '0;
            psc_act <= '0;
            pcnt    <= '0;
        end else begin
            if (psc_wr)  psc_sh  <= psc_wdata;
            if (upd_evt) psc_act <= psc_sh;
            if (force_upd)  pcnt <= '0;
            else if (run)   pcnt <= tick ? '0 : pcnt + 1'b1;
        end
    end

    // divider phase never runs past the active divide value
    p_phase_bound_r2: assert property (@(posedge clk) disable iff (rst)
        pcnt <= psc_act);

endmodule

// File: rtl/pwm4_counter.sv
module pwm4_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             force_upd,
    input  logic             reload_wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt,
    output logic             upd_evt,
    output logic             upd_pulse
);

    logic [CNT_W-1:0] top_sh, top_act;
    logic             wrap;

    assign wrap    = tick && (cnt == top_act);
    assign upd_evt = force_upd || wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            top_sh    <= '0;
            top_act   <= '0;
            cnt       <= '0;
            upd_pulse <= 1'b0;
        end else begin
            if (reload_wr) top_sh  <= wdata;
            if (upd_evt)   top_act <= top_sh;
            if (force_upd)  cnt <= '0;
            else if (tick)  cnt <= wrap ? '0 : cnt + 1'b1;
            upd_pulse <= upd_evt;
        end
    end

    p_wrap_zero_r1: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (cnt == '0) && upd_pulse);

    p_within_top_r1: assert property (@(posedge clk) disable iff (rst)
        cnt <= top_act);

    p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (!tick && !force_upd) |=> $stable(cnt));

endmodule

// File: rtl/pwm4_channel.sv
module pwm4_channel
    import pwm4_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             preload,
    input  logic             upd_evt,
    input  logic [CNT_W-1:0] cnt,
    input  logic             drive_en,
    output logic             pwm
);

    logic [CNT_W-1:0] thr_sh, thr_act;

    assign pwm = drive_en && mode1_high(32'(cnt), 32'(thr_act));

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_sh  <= '0;
            thr_act <= '0;
        end else begin
            if (cmp_wr)             thr_sh  <= wdata;
            if (upd_evt)            thr_act <= thr_sh;
            if (cmp_wr && !preload) thr_act <= wdata;
        end
    end

    p_buffered_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (preload && !upd_evt) |=> $stable(thr_act));

    p_zero_low_r6: assert property (@(posedge clk) disable iff (rst)
        (thr_act == '0) |-> !pwm);

endmodule

// File: rtl/pwm4_timer.sv
module pwm4_timer
    import pwm4_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [NUM_CH-1:0] pwm_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              upd_o
);

    run_ctl_t          ctl_q;
    logic [NUM_CH-1:0] ch_en_q, pre_q;
    logic              ctrl_wr, force_upd, tick, upd_evt;

    assign ctrl_wr   = wr_en && (wr_addr == RA_CTRL);
    assign force_upd = ctrl_wr && wr_data[CB_UG];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q   <= '0;
            ch_en_q <= '0;
            pre_q   <= '0;
        end else begin
            if (ctrl_wr) begin
                ctl_q.cen <= wr_data[CB_CEN];
                ctl_q.moe <= wr_data[CB_MOE];
            end
            if (wr_en && wr_addr == RA_CHCFG) begin
                ch_en_q <= wr_data[NUM_CH-1:0];
                pre_q   <= wr_data[2*NUM_CH-1:NUM_CH];
            end
        end
    end

    pwm4_prescaler #(.PSC_W(CNT_W)) u_psc (
        .clk       (clk),
        .rst       (rst),
        .run       (ctl_q.cen),
        .psc_wr    (wr_en && wr_addr == RA_PSC),
        .psc_wdata (wr_data),
        .upd_evt   (upd_evt),
        .force_upd (force_upd),
        .tick      (tick)
    );

    pwm4_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .force_upd (force_upd),
        .reload_wr (wr_en && wr_addr == RA_RELOAD),
        .wdata     (wr_data),
        .cnt       (count_o),
        .upd_evt   (upd_evt),
        .upd_pulse (upd_o)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm4_channel #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .cmp_wr   (wr_en && wr_addr == ADDR_W'(RA_CMP0 + g)),
            .wdata    (wr_data),
            .preload  (pre_q[g]),
            .upd_evt  (upd_evt),
            .cnt      (count_o),
            .drive_en (ctl_q.moe && ch_en_q[g]),
            .pwm      (pwm_o[g])
        );
    end

    p_strobe_restart_r5: assert property (@(posedge clk) disable iff (rst)
        force_upd |=> (count_o == '0) && upd_o);

    p_gate_low_r7: assert property (@(posedge clk) disable iff (rst)
        !ctl_q.moe |-> (pwm_o == '0));

endmodule

// File: tb/sim_pwm4_timer.sv
module sim_pwm4_timer;

    logic        clk = 1'b0;
    logic        rst, wr_en;
    logic [3:0]  wr_addr;
    logic [15:0] wr_data;
    logic [3:0]  pwm;
    logic [15:0] cnt;
    logic        upd;
    int n_run = 0, n_fail = 0;

    always #10 clk = ~clk;

    pwm4_timer #(.CNT_W(16), .NUM_CH(4)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pwm_o(pwm), .count_o(cnt), .upd_o(upd)
    );

    // divider, top, thr0..3, expected high cycles per period ch0..3
    localparam int VT [4][10] = '{
        '{0, 9, 0, 3, 10, 15,  0,  3, 10, 10},
        '{2, 4, 1, 5,  2,  0,  3, 15,  6,  0},
        '{1, 7, 8, 4,  7,  1, 16,  8, 14,  2},
        '{0, 0, 0, 1,  2,  0,  0,  1,  1,  0}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        wr_en   = 1'b1;
        wr_addr = 4'(a);
        wr_data = 16'(d);
        @(posedge clk);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_cnt(input int v);
        while (int'(cnt) != v) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int s [6];
        int mx, zeros, pulses, base;
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        chk("R10 pwm", int'(pwm), 0);
        chk("R10 count", int'(cnt), 0);
        chk("R10 upd", int'(upd), 0);
        rst = 1'b0;
        @(negedge clk);
        wr(1, 'hFF);

        // table walk: duty per channel (R6, R2) and one forced pulse (R5)
        for (int v = 0; v < 4; v++) begin
            int hi [4];
            int per;
            per = (VT[v][1] + 1) * (VT[v][0] + 1);
            wr(2, VT[v][0]);
            wr(3, VT[v][1]);
            for (int c = 0; c < 4; c++) wr(4 + c, VT[v][2+c]);
            wr(0, 7);
            pulses = 0;
            for (int c = 0; c < 4; c++) hi[c] = 0;
            for (int k = 0; k < per; k++) begin
                for (int c = 0; c < 4; c++) hi[c] += int'(pwm[c]);
                pulses += int'(upd);
                @(negedge clk);
            end
            for (int c = 0; c < 4; c++) chk($sformatf("R6 vec%0d ch%0d", v, c), hi[c], VT[v][6+c]);
            chk($sformatf("R5 vec%0d pulse", v), pulses, 1);
            wr(0, 0);
        end

        // R1 R2 R9: three periods, divider 1, top 4
        wr(2, 1); wr(3, 4); wr(0, 7);
        mx = 0; zeros = 0; pulses = 0;
        for (int k = 0; k < 30; k++) begin
            if (int'(cnt) > mx) mx = int'(cnt);
            if (cnt == 0) zeros++;
            pulses += int'(upd);
            @(negedge clk);
        end
        chk("R1 max count", mx, 4);
        chk("R2 cycles at zero", zeros, 6);
        chk("R9 pulses", pulses, 3);

        // R8: run bit clear freezes count
        wr(0, 2);
        base = int'(cnt);
        repeat (5) @(negedge clk);
        chk("R8 frozen", int'(cnt), base);

        // R3 top value buffered
        wr(2, 0); wr(3, 9); wr(0, 7);
        wait_cnt(2);
        wr(3, 3);
        mx = 0;
        for (int k = 0; k < 12; k++) begin
            if (int'(cnt) > mx) mx = int'(cnt);
            @(negedge clk);
        end
        chk("R3 old top kept", mx, 9);
        mx = 0;
        for (int k = 0; k < 8; k++) begin
            if (int'(cnt) > mx) mx = int'(cnt);
            @(negedge clk);
        end
        chk("R3 new top", mx, 3);

        // R3 divider buffered
        wait_cnt(1);
        wr(2, 2);
        for (int k = 0; k < 6; k++) begin
            s[k] = int'(cnt);
            @(negedge clk);
        end
        chk("R3 old divider", s[1], 3);
        chk("R3 new divider hold", s[4], 0);
        chk("R3 new divider step", s[5], 1);

        // R4 buffered threshold
        wr(2, 0); wr(3, 9); wr(4, 3); wr(0, 7);
        wait_cnt(5);
        wr(4, 8);
        chk("R4 old thr at 6", int'(pwm[0]), 0);
        wait_cnt(7);
        chk("R4 old thr at 7", int'(pwm[0]), 0);
        wait_cnt(0);
        wait_cnt(7);
        chk("R4 new thr at 7", int'(pwm[0]), 1);

        // R4 write-through
        wr(1, 'hEF);
        wait_cnt(2);
        wr(4, 0);
        chk("R4 write-through", int'(pwm[0]), 0);
        wr(1, 'hFF);

        // R6 above top, R7 gating
        for (int c = 0; c < 4; c++) wr(4 + c, 15);
        wr(0, 7);
        chk("R6 above top high", int'(pwm), 15);
        wr(1, 'hF5);
        chk("R7 channel gate", int'(pwm), 5);
        wr(0, 1);
        chk("R7 global gate", int'(pwm), 0);

        // R5 strobe mid-period
        wr(0, 3);
        wait_cnt(6);
        wr(0, 7);
        chk("R5 count cleared", int'(cnt), 0);
        chk("R5 pulse", int'(upd), 1);
        @(negedge clk);
        chk("R5 strobe not kept pulse", int'(upd), 0);
        chk("R5 strobe not kept count", int'(cnt), 1);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule